// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers interrupt requests from a set of numbered sources and routes them to a small number of target contexts, for example the machine and supervisor levels of one processor. Each source has a three-bit priority and a pending flag. Each context has its own enable mask over the sources, its own priority threshold and one output line. A context's line is high while at least one source is pending, enabled for that context, and ranked above that context's threshold.

Software works through a 32-bit register bus with one request per cycle. A handler reads the context's claim register to obtain the winning source number. The read also takes that source out of the pending set. After servicing the source, the handler writes the same number back to the same register to complete it. Between claim and completion the source is held in service, and a new request on that line is not recorded. Source number 0 is reserved to mean "nothing to claim". The request inputs are assumed to come from separate gateway logic.

Top module: `plic_core`

## Requirements
- R1: After reset every priority, enable, threshold and pending bit is zero, every `irq_out` bit is low and `bus_ready` is low.
- R2: A request held for one cycle with `bus_req` high produces `bus_ready` high in the following cycle. On a read, `bus_rdata` carries the read value in that same cycle. `bus_ready` is low in any cycle that does not follow a request.
- R3: The priority of source k is the word at byte address 4·k. Only bits [2:0] are stored, and the upper bits read as zero. Addresses for source 0 and for numbers above NUM_SRC read zero, and writes to them change nothing.
- R4: Pending flags are read-only words from 0x1000 upward. Source k sits in word k/32 at bit k%32. A cycle with the source's request input high sets its flag. Writes to these words have no effect.
- R5: The enable mask of context c starts at 0x2000 + c·0x80 and uses the k/32, k%32 layout. Bit 0 of word 0 always reads zero.
- R6: The threshold of context c is at 0x200000 + c·0x1000, bits [2:0]. `irq_out[c]` is high exactly when some pending source enabled for c has a priority strictly greater than that threshold. Priority 0 therefore never raises the line, and threshold 7 masks everything.
- R7: Reading the claim register at threshold address + 4 returns the eligible source with the highest priority, with equal priorities going to the lowest number. The read clears that source's pending flag. If no source is eligible, the read returns 0 and changes nothing.
- R8: After a claim, the source's pending flag is not set again, whatever its request input does, until a completion is written. Writing the source number to the claim register of a context that has the source enabled completes it, and the request input is sampled again from the next cycle.
- R9: A completion written to a context in which the source is not enabled is ignored, and the source stays in service.
- R10: A pending source whose enable bit is clear keeps its pending flag and can neither be claimed nor raise the line.
- R11: Contexts are independent: each uses only its own enable mask and threshold, and a source enabled in two contexts raises both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | NUM_SRC | Request inputs; bit i belongs to source i+1 |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access done, one cycle after bus_req |
| irq_out | output | NUM_CTX | Interrupt line of each context |

## Verification
Corrupted state in this block surfaces quickly at the ports. A wrong pending or in-service flag appears on `irq_out` in the cycle after the edge that stored it, and on the next claim read. A wrong enable or threshold register appears on the same line as soon as a source of suitable priority is pending. Arbitration errors surface only on claim reads, so the directed tests line up competing sources with equal and unequal priorities before claiming. The in-service lock is probed by holding a request high across a claim and across both an ignored completion and an accepted one, then reading the pending words back.

// File: rtl/plic_pkg.sv
package plic_pkg;
   localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
   localparam logic [31:0] PEND_END   = 32'h0000_1080;
   localparam logic [31:0] EN_BASE    = 32'h0000_2000;
   localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
   localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
   localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_PRIO,
      RK_PEND,
      RK_EN,
      RK_THR,
      RK_CLAIM
   } reg_kind_e;
endpackage

// File: rtl/plic_src_state.sv
module plic_src_state #(
   parameter int NUM_SRC = 63
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_in,
   input  logic [NUM_SRC-1:0] take,
   input  logic [NUM_SRC-1:0] done,
   output logic [NUM_SRC-1:0] pend,
   output logic [NUM_SRC-1:0] busy
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            busy[i] <= 1'b0;
         end else if (take[i]) begin
            pend[i] <= 1'b0;
            busy[i] <= 1'b1;
         end else begin
            if (req_in[i] && !busy[i]) pend[i] <= 1'b1;
            if (done[i])               busy[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/plic_ctx_select.sv
module plic_ctx_select #(
   parameter int NUM_SRC = 63,
   parameter int PRIO_W  = 3,
   parameter int ID_W    = 6
) (
   input  logic [NUM_SRC-1:0]             pend,
   input  logic [NUM_SRC-1:0]             en,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]              thr,
   output logic [ID_W-1:0]                best_id,
   output logic                           irq
);
   logic [PRIO_W-1:0] best_p;

   // Running maximum seeded with the threshold: strict compare gives both
   // the "above threshold" rule and lowest-number wins on ties.
   always_comb begin
      best_p  = thr;
      best_id = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend[i] && en[i] && (prio[i] > best_p)) begin
            best_p  = prio[i];
            best_id = ID_W'(i + 1);
         end
      end
   end

   assign irq = (best_id != '0);
endmodule

// File: rtl/plic_core.sv
module plic_core
   import plic_pkg::*;
#(
   parameter int NUM_SRC = 63,
   parameter int NUM_CTX = 2,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_ready,
   output logic [NUM_CTX-1:0] irq_out
);
   localparam int ID_W   = $clog2(NUM_SRC + 1);
   localparam int CTX_IW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_chk_src
      $error("NUM_SRC must lie in 1..1023");
   end
   if (NUM_CTX < 1 || NUM_CTX > 64) begin : g_chk_ctx
      $error("NUM_CTX must lie in 1..64");
   end
   if (ADDR_W < 22 || ADDR_W > 31) begin : g_chk_addr
      $error("ADDR_W must lie in 22..31");
   end
   if (PRIO_W < 1 || PRIO_W > 31) begin : g_chk_prio
      $error("PRIO_W must lie in 1..31");
   end

   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
   logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
   logic [NUM_SRC-1:0]              pend_vec, busy_vec, take_vec, done_vec;
   logic [NUM_CTX-1:0][ID_W-1:0]    best_id;

   // ---------------- address decode ----------------
   logic [31:0]       a32;
   reg_kind_e         dk;
   logic [9:0]        did;
   logic [4:0]        dword;
   logic [CTX_IW-1:0] dctx;
   logic              id_ok;

   assign a32 = {{(32-ADDR_W){1'b0}}, bus_addr};

   always_comb begin
      dk    = RK_NONE;
      did   = a32[11:2];
      dword = a32[6:2];
      dctx  = '0;
      if (a32[1:0] == 2'b00) begin
         if (a32 < PEND_BASE) begin
            dk = RK_PRIO;
         end else if (a32 < PEND_END) begin
            dk = RK_PEND;
         end else if (a32 >= EN_BASE && a32 < EN_BASE + NUM_CTX * EN_STRIDE) begin
            dk   = RK_EN;
            dctx = a32[7+CTX_IW-1:7];
         end else if (a32 >= CTX_BASE && a32 < CTX_BASE + NUM_CTX * CTX_STRIDE) begin
            dctx = a32[12+CTX_IW-1:12];
            if (a32[11:0] == 12'h000)      dk = RK_THR;
            else if (a32[11:0] == 12'h004) dk = RK_CLAIM;
         end
      end
   end

   assign id_ok = (did != '0) && (int'(did) <= NUM_SRC);

   function automatic logic [31:0] pack_word(input logic [NUM_SRC-1:0] v,
                                             input logic [4:0] w);
      logic [31:0] r;
      r = '0;
      for (int b = 0; b < 32; b++) begin
         int id;
         id = int'(w) * 32 + b;
         if (id >= 1 && id <= NUM_SRC) r[b] = v[id-1];
      end
      return r;
   endfunction

   // ---------------- register writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
      end else if (bus_req && bus_we) begin
         case (dk)
            RK_PRIO: if (id_ok) prio_q[int'(did) - 1] <= bus_wdata[PRIO_W-1:0];
            RK_THR:  thr_q[dctx] <= bus_wdata[PRIO_W-1:0];
            RK_EN: begin
               for (int b = 0; b < 32; b++) begin
                  int id;
                  id = int'(dword) * 32 + b;
                  if (id >= 1 && id <= NUM_SRC) en_q[dctx][id-1] <= bus_wdata[b];
               end
            end
            default: ;
         endcase
      end
   end

   // ---------------- claim / complete ----------------
   logic cmp_ok;
   assign cmp_ok = (bus_wdata != '0) && (bus_wdata <= 32'(NUM_SRC));

   always_comb begin
      take_vec = '0;
      done_vec = '0;
      if (bus_req && dk == RK_CLAIM) begin
         if (!bus_we && best_id[dctx] != '0)
            take_vec[int'(best_id[dctx]) - 1] = 1'b1;
         if (bus_we && cmp_ok && en_q[dctx][int'(bus_wdata[ID_W-1:0]) - 1])
            done_vec[int'(bus_wdata[ID_W-1:0]) - 1] = 1'b1;
      end
   end

   plic_src_state #(.NUM_SRC(NUM_SRC)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (src_irq),
      .take   (take_vec),
      .done   (done_vec),
      .pend   (pend_vec),
      .busy   (busy_vec)
   );

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      plic_ctx_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
         .pend    (pend_vec),
         .en      (en_q[c]),
         .prio    (prio_q),
         .thr     (thr_q[c]),
         .best_id (best_id[c]),
         .irq     (irq_out[c])
      );
   end

   // ---------------- read path ----------------
   logic [31:0] rd_d;
   always_comb begin
      rd_d = '0;
      case (dk)
         RK_PRIO:  if (id_ok) rd_d = 32'(prio_q[int'(did) - 1]);
         RK_PEND:  rd_d = pack_word(pend_vec, dword);
         RK_EN:    rd_d = pack_word(en_q[dctx], dword);
         RK_THR:   rd_d = 32'(thr_q[dctx]);
         RK_CLAIM: rd_d = 32'(best_id[dctx]);
         default:  rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ready <= bus_req;
         bus_rdata <= (bus_req && !bus_we) ? rd_d : '0;
      end
   end
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
   parameter int NUM_SRC = 63,
   parameter int NUM_CTX = 2,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 26
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             bus_req,
   input logic                             bus_we,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic [31:0]                      bus_rdata,
   input logic                             bus_ready,
   input logic [NUM_CTX-1:0]               irq_out,
   input logic [NUM_SRC-1:0]               pend_vec,
   input logic [NUM_SRC-1:0]               busy_vec,
   input logic [NUM_CTX-1:0][PRIO_W-1:0]   thr_q
);
   a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ready);

   a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !bus_ready);

   a_r8_held_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec & busy_vec) == '0);

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
      logic clm_rd;
      assign clm_rd = bus_req && !bus_we &&
                      (bus_addr == ADDR_W'(32'h0020_0004 + c * 32'h1000));

      a_r6_max_threshold_masks: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_q[c] == {PRIO_W{1'b1}}) |-> !irq_out[c]);

      a_r7_claim_gives_id: assert property (@(posedge clk) disable iff (!rst_n)
         (clm_rd && irq_out[c]) |=> (bus_rdata != 32'd0) && (bus_rdata <= 32'(NUM_SRC)));

      a_r7_claim_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (clm_rd && !irq_out[c]) |=> (bus_rdata == 32'd0));

      a_r7_claim_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
         (clm_rd && irq_out[c]) |=>
            (bus_rdata == 32'd0 || bus_rdata > 32'(NUM_SRC) || !pend_vec[bus_rdata[9:0] - 10'd1]));
   end
endmodule

bind plic_core plic_core_chk #(
   .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_ready (bus_ready),
   .irq_out   (irq_out),
   .pend_vec  (pend_vec),
   .busy_vec  (busy_vec),
   .thr_q     (thr_q)
);

// File: tb/tb_plic_core.sv
module tb_plic_core;
   localparam int NS = 63;
   localparam int NC = 2;
   localparam int AW = 26;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_irq = '0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_ready;
   logic [NC-1:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   plic_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .irq_out(irq_out)
   );

   function automatic logic [AW-1:0] a_prio(int id);  return AW'(4 * id); endfunction
   function automatic logic [AW-1:0] a_pend(int w);   return AW'(32'h1000 + 4 * w); endfunction
   function automatic logic [AW-1:0] a_en(int c, int w); return AW'(32'h2000 + 32'h80 * c + 4 * w); endfunction
   function automatic logic [AW-1:0] a_thr(int c);    return AW'(32'h200000 + 32'h1000 * c); endfunction
   function automatic logic [AW-1:0] a_clm(int c);    return AW'(32'h200004 + 32'h1000 * c); endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      check("R2 write ready", 32'(bus_ready), 32'd1);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      check("R2 read ready", 32'(bus_ready), 32'd1);
      d = bus_rdata;
      bus_req = 1'b0;
   endtask

   task automatic expect_rd(string tag, logic [AW-1:0] a, logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(tag, d, exp);
   endtask

   task automatic pulse_src(logic [NS-1:0] m);
      @(negedge clk);
      src_irq = src_irq | m;
      @(negedge clk);
      src_irq = src_irq & ~m;
   endtask

   task automatic t_reset;
      check("R1 irq_out", 32'(irq_out), 32'd0);
      check("R1 ready low", 32'(bus_ready), 32'd0);
      idle(1);
      check("R2 idle ready low", 32'(bus_ready), 32'd0);
      expect_rd("R1 prio reset", a_prio(1), 32'd0);
      expect_rd("R1 pending reset", a_pend(0), 32'd0);
      expect_rd("R1 enable reset", a_en(1, 0), 32'd0);
      expect_rd("R1 threshold reset", a_thr(0), 32'd0);
   endtask

   task automatic t_prio_regs;
      bus_write(a_prio(5), 32'hFFFF_FFFF);
      expect_rd("R3 prio width", a_prio(5), 32'd7);
      bus_write(a_prio(0), 32'd3);
      expect_rd("R3 source 0", a_prio(0), 32'd0);
      bus_write(a_prio(64), 32'd3);
      expect_rd("R3 beyond range", a_prio(64), 32'd0);
   endtask

   task automatic t_pending;
      logic [NS-1:0] m;
      m = '0; m[3-1] = 1'b1; m[40-1] = 1'b1;
      pulse_src(m);
      expect_rd("R4 pending word0", a_pend(0), 32'h0000_0008);
      expect_rd("R4 pending word1", a_pend(1), 32'h0000_0100);
      bus_write(a_pend(0), 32'h0);
      expect_rd("R4 pending read-only", a_pend(0), 32'h0000_0008);
   endtask

   task automatic t_enable;
      bus_write(a_prio(3), 32'd2);
      bus_write(a_prio(40), 32'd5);
      check("R10 disabled no irq", 32'(irq_out), 32'd0);
      expect_rd("R7 empty claim", a_clm(0), 32'd0);
      expect_rd("R10 pending kept", a_pend(0), 32'h0000_0008);
      bus_write(a_en(0, 0), 32'hFFFF_FFFF);
      expect_rd("R5 enable bit0 zero", a_en(0, 0), 32'hFFFF_FFFE);
      check("R11 only ctx0 line", 32'(irq_out), 32'd1);
   endtask

   task automatic t_threshold;
      bus_write(a_thr(0), 32'd2);
      check("R6 equal not above", 32'(irq_out), 32'd0);
      bus_write(a_thr(0), 32'd1);
      check("R6 above threshold", 32'(irq_out), 32'd1);
      bus_write(a_thr(0), 32'hFF);
      expect_rd("R6 threshold width", a_thr(0), 32'd7);
      check("R6 threshold 7 masks", 32'(irq_out), 32'd0);
      bus_write(a_thr(0), 32'd0);
   endtask

   task automatic t_claim_order;
      bus_write(a_en(0, 1), 32'h0000_0100);
      expect_rd("R7 highest first", a_clm(0), 32'd40);
      expect_rd("R7 claim clears", a_pend(1), 32'd0);
      expect_rd("R7 next claim", a_clm(0), 32'd3);
      expect_rd("R7 drained", a_clm(0), 32'd0);
      check("R7 line low after drain", 32'(irq_out), 32'd0);
   endtask

   task automatic t_complete;
      @(negedge clk); src_irq[40-1] = 1'b1;
      idle(2);
      expect_rd("R8 held source ignores request", a_pend(1), 32'd0);
      bus_write(a_clm(1), 32'd40);
      idle(2);
      expect_rd("R9 foreign completion ignored", a_pend(1), 32'd0);
      bus_write(a_clm(0), 32'd40);
      idle(1);
      @(negedge clk); src_irq[40-1] = 1'b0;
      expect_rd("R8 completion re-arms", a_pend(1), 32'h0000_0100);
   endtask

   task automatic t_tie;
      logic [NS-1:0] m;
      bus_write(a_prio(10), 32'd6);
      bus_write(a_prio(12), 32'd6);
      m = '0; m[10-1] = 1'b1; m[12-1] = 1'b1;
      pulse_src(m);
      expect_rd("R7 tie lowest id", a_clm(0), 32'd10);
      expect_rd("R7 tie second", a_clm(0), 32'd12);
      expect_rd("R7 lower prio last", a_clm(0), 32'd40);
      expect_rd("R7 tie drained", a_clm(0), 32'd0);
   endtask

   task automatic t_contexts;
      logic [NS-1:0] m;
      bus_write(a_en(1, 0), 32'h0000_0008);
      bus_write(a_clm(0), 32'd3);
      m = '0; m[3-1] = 1'b1;
      pulse_src(m);
      check("R11 both lines", 32'(irq_out), 32'd3);
      expect_rd("R11 ctx1 claim", a_clm(1), 32'd3);
      check("R11 both cleared", 32'(irq_out), 32'd0);
      m = '0; m[20-1] = 1'b1;
      pulse_src(m);
      check("R6 priority 0 silent", 32'(irq_out), 32'd0);
      expect_rd("R6 priority 0 unclaimable", a_clm(0), 32'd0);
      expect_rd("R6 priority 0 stays pending", a_pend(0), 32'h0010_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prio_regs();
      t_pending();
      t_enable();
      t_threshold();
      t_claim_order();
      t_complete();
      t_tie();
      t_contexts();
      idle(2);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule